// File: doc/BRIEF.md
# Serial Port Mode and Clock Selector

This block holds the configuration byte of a shared serial port and turns it into the signals the rest of the port needs. It decodes the operating mode into five mutually exclusive strobes: SPI master, SPI slave, I2C slave, UART and idle. It also reports the input-filter length that the I2C logic should apply. A UART select bit takes priority over the three-bit mode field.

In the five SPI master codes the block also produces the shift-clock enable for the SPI engine. This is a single-cycle pulse in the system clock domain, one per SPI clock period. The period comes from one of five sources: the system clock divided by 4, 16 or 64; the rising edges of a slow asynchronous sub-clock; or every second pulse of a timer compare-match input. The divider restarts whenever the mode, the UART select or the enable bit changes, so a new setting never starts with a shortened period.

The shift engines, the UART, the I2C protocol logic and the filter itself live elsewhere. Software writes the configuration byte through a simple write strobe, and reads its current value back on a dedicated output.

Top module: `sms_mode_clk`

## Requirements
- R1: After reset the configuration reads 0xE0, only the idle strobe is high, `sck_en` is low and `deb_valid` is low.
- R2: The configuration byte is laid out as: bits [7:5] mode code, bit 4 UART select, bits [3:2] filter select, bit 1 enable, bit 0 a spare bit that is stored and has no effect. A write with `wr_en` high appears unchanged on `cfg_rd` after that clock edge.
- R3: With UART select at 0, the strobes follow the mode code one cycle after `cfg_rd` changes. Codes 000 to 100 give `spi_m`, 101 gives `spi_s`, 110 gives `i2c_s` and 111 gives `idle_m`. Exactly one strobe is high in every cycle.
- R4: With UART select at 1, only `uart_m` is high whatever the mode code is, and `sck_en` stays low.
- R5: With enable at 1 and UART select at 0, codes 000, 001 and 010 give one `sck_en` pulse every 4, 16 and 64 system clocks respectively.
- R6: With code 011 enabled, `sck_en` gives one pulse for each rising edge of `sub_clk`, after a two-flop synchronizer.
- R7: With code 100 enabled, `sck_en` pulses on every second `tmr_match` pulse, counted from the moment the setting took effect.
- R8: `sck_en` stays low while enable is 0, and in codes 101, 110 and 111.
- R9: A write that changes the mode code, the UART select or the enable bit restarts the divider. With a divide ratio N, the first pulse comes N+1 edges after the write edge, and later pulses follow every N edges.
- R10: `deb_cycles` reads 0 for filter select 00, 2 for 01 and 4 for 1x. `deb_valid` is high only in I2C slave mode with UART select at 0. Outside that mode `deb_cycles` reads 0. Both outputs are updated in the same cycle as the strobes.
- R11: Every `sck_en` pulse lasts exactly one system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_clk | input | 1 | Slow asynchronous sub-clock |
| tmr_match | input | 1 | Timer compare-match pulse, system clock domain |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 8 | Configuration write data |
| cfg_rd | output | 8 | Current configuration byte |
| spi_m | output | 1 | SPI master mode strobe |
| spi_s | output | 1 | SPI slave mode strobe |
| i2c_s | output | 1 | I2C slave mode strobe |
| uart_m | output | 1 | UART mode strobe |
| idle_m | output | 1 | Unused-mode strobe |
| deb_valid | output | 1 | Filter length is meaningful |
| deb_cycles | output | 3 | Filter length in system clocks |
| sck_en | output | 1 | SPI master shift-clock enable pulse |

## Verification
The bench switches the port from a long divide ratio to a short one in the middle of a period. A divider that did not restart would either keep counting past the new limit and miss its first pulse, or emit a first pulse that is too early. It checks that a UART select of 1 overrides every mode code: a design that let the mode bits leak through would show two strobes, or clock enables, while in UART mode. In timer mode it sends back-to-back match pulses and checks for exactly half as many enables. A design that passed matches through one for one would emit twice as many. Random bytes cover every filter select in and out of I2C mode, which catches a `deb_valid` that does not check the mode or the UART select.

// File: rtl/sms_pkg.sv
package sms_pkg;

  typedef enum logic [2:0] {
    MC_DIV_A = 3'd0,
    MC_DIV_B = 3'd1,
    MC_DIV_C = 3'd2,
    MC_SUB   = 3'd3,
    MC_TMR   = 3'd4,
    MC_SLV   = 3'd5,
    MC_I2C   = 3'd6,
    MC_IDLE  = 3'd7
  } mode_code_e;

  typedef struct packed {
    logic [2:0] mode;
    logic       uart;
    logic [1:0] deb;
    logic       en;
    logic       spare;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{mode: 3'b111, uart: 1'b0, deb: 2'b00, en: 1'b0, spare: 1'b0};

  localparam int STB_W    = 5;
  localparam int STB_SPIM = 0;
  localparam int STB_SPIS = 1;
  localparam int STB_I2C  = 2;
  localparam int STB_UART = 3;
  localparam int STB_IDLE = 4;

endpackage

// File: rtl/sms_cfg_reg.sv
module sms_cfg_reg
  import sms_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output cfg_t       cfg,
  output logic       restart
);

  cfg_t nxt;
  logic changes;

  always_comb begin
    nxt     = cfg_t'(wr_data);
    changes = (nxt.mode != cfg.mode) || (nxt.uart != cfg.uart) || (nxt.en != cfg.en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= CFG_RESET;
      restart <= 1'b0;
    end else begin
      restart <= wr_en && changes;
      if (wr_en) cfg <= nxt;
    end
  end

endmodule

// File: rtl/sms_mode_dec.sv
module sms_mode_dec
  import sms_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode,
  input  logic             uart,
  input  logic [1:0]       deb,
  output logic [STB_W-1:0] strobes,
  output logic             deb_valid,
  output logic [2:0]       deb_cycles
);

  logic [STB_W-1:0] stb_d;
  logic             dv_d;
  logic [2:0]       dc_d;

  always_comb begin
    stb_d = '0;
    if (uart) begin
      stb_d[STB_UART] = 1'b1;
    end else begin
      case (mode_code_e'(mode))
        MC_SLV:  stb_d[STB_SPIS] = 1'b1;
        MC_I2C:  stb_d[STB_I2C]  = 1'b1;
        MC_IDLE: stb_d[STB_IDLE] = 1'b1;
        default: stb_d[STB_SPIM] = 1'b1;
      endcase
    end
    dv_d = !uart && (mode_code_e'(mode) == MC_I2C);
    if (!dv_d)       dc_d = 3'd0;
    else if (deb[1]) dc_d = 3'd4;
    else if (deb[0]) dc_d = 3'd2;
    else             dc_d = 3'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strobes    <= STB_W'(1) << STB_IDLE;
      deb_valid  <= 1'b0;
      deb_cycles <= 3'd0;
    end else begin
      strobes    <= stb_d;
      deb_valid  <= dv_d;
      deb_cycles <= dc_d;
    end
  end

endmodule

// File: rtl/sms_edge_sync.sv
module sms_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] sr;
  logic              prev;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sr[0] <= 1'b0;
        else     sr[0] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sr[i] <= 1'b0;
        else     sr[i] <= sr[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      rise <= 1'b0;
    end else begin
      prev <= sr[STAGES-1];
      rise <= sr[STAGES-1] && !prev;
    end
  end

endmodule

// File: rtl/sms_sck_gen.sv
module sms_sck_gen
  import sms_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode,
  input  logic       uart,
  input  logic       en,
  input  logic       restart,
  input  logic       sub_rise,
  input  logic       tmr_match,
  output logic       sck_en
);

  localparam int CW = $clog2(DIV_C);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          use_div;
  logic          active;
  logic          tog;

  always_comb begin
    lim     = '0;
    use_div = 1'b0;
    case (mode_code_e'(mode))
      MC_DIV_A: begin lim = CW'(DIV_A - 1); use_div = 1'b1; end
      MC_DIV_B: begin lim = CW'(DIV_B - 1); use_div = 1'b1; end
      MC_DIV_C: begin lim = CW'(DIV_C - 1); use_div = 1'b1; end
      default:  begin lim = '0;             use_div = 1'b0; end
    endcase
    active = en && !uart && (mode <= 3'(MC_TMR));
  end

  always_ff @(posedge clk) begin
    if (rst || restart || !active) begin
      cnt    <= '0;
      tog    <= 1'b0;
      sck_en <= 1'b0;
    end else begin
      sck_en <= 1'b0;
      if (use_div) begin
        if (cnt == lim) begin
          cnt    <= '0;
          sck_en <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (mode_code_e'(mode) == MC_SUB) begin
        sck_en <= sub_rise;
      end else if (tmr_match) begin
        tog    <= !tog;
        sck_en <= tog;
      end
    end
  end

endmodule

// File: rtl/sms_mode_clk.sv
module sms_mode_clk
  import sms_pkg::*;
#(
  parameter int DIV_A       = 4,
  parameter int DIV_B       = 16,
  parameter int DIV_C       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sub_clk,
  input  logic       tmr_match,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] cfg_rd,
  output logic       spi_m,
  output logic       spi_s,
  output logic       i2c_s,
  output logic       uart_m,
  output logic       idle_m,
  output logic       deb_valid,
  output logic [2:0] deb_cycles,
  output logic       sck_en
);

  cfg_t             cfg;
  logic             restart;
  logic             sub_rise;
  logic [STB_W-1:0] strobes;

  sms_cfg_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cfg     (cfg),
    .restart (restart)
  );

  sms_mode_dec u_dec (
    .clk        (clk),
    .rst        (rst),
    .mode       (cfg.mode),
    .uart       (cfg.uart),
    .deb        (cfg.deb),
    .strobes    (strobes),
    .deb_valid  (deb_valid),
    .deb_cycles (deb_cycles)
  );

  sms_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (sub_clk),
    .rise     (sub_rise)
  );

  sms_sck_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_gen (
    .clk       (clk),
    .rst       (rst),
    .mode      (cfg.mode),
    .uart      (cfg.uart),
    .en        (cfg.en),
    .restart   (restart),
    .sub_rise  (sub_rise),
    .tmr_match (tmr_match),
    .sck_en    (sck_en)
  );

  assign cfg_rd = cfg;
  assign spi_m  = strobes[STB_SPIM];
  assign spi_s  = strobes[STB_SPIS];
  assign i2c_s  = strobes[STB_I2C];
  assign uart_m = strobes[STB_UART];
  assign idle_m = strobes[STB_IDLE];

endmodule

// File: rtl/sms_mode_clk_chk.sv
module sms_mode_clk_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] cfg_rd,
  input logic       spi_m,
  input logic       spi_s,
  input logic       i2c_s,
  input logic       uart_m,
  input logic       idle_m,
  input logic       deb_valid,
  input logic       sck_en
);

  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) |-> cfg_rd == $past(wr_data));

  p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    $countones({spi_m, spi_s, i2c_s, uart_m, idle_m}) == 1);

  p_uart_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    uart_m |-> !sck_en);

  p_no_clk_modes_r8: assert property (@(posedge clk) disable iff (rst)
    (spi_s || i2c_s || idle_m) |-> !sck_en);

  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_rd[1]) |-> !sck_en);

  p_deb_only_i2c_r10: assert property (@(posedge clk) disable iff (rst)
    deb_valid |-> i2c_s);

  p_single_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    sck_en |=> !sck_en);

endmodule

bind sms_mode_clk sms_mode_clk_chk u_chk (.*);

// File: tb/sms_mode_clk_test.sv
module sms_mode_clk_test;

  localparam int CLK_PERIOD = 10;
  localparam int SUB_HALF   = 93;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sub_clk = 1'b0;
  logic       tmr_match = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] cfg_rd;
  logic       spi_m, spi_s, i2c_s, uart_m, idle_m, deb_valid, sck_en;
  logic [2:0] deb_cycles;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  int sub_rises = 0;

  sms_mode_clk uut (
    .clk(clk), .rst(rst), .sub_clk(sub_clk), .tmr_match(tmr_match),
    .wr_en(wr_en), .wr_data(wr_data), .cfg_rd(cfg_rd),
    .spi_m(spi_m), .spi_s(spi_s), .i2c_s(i2c_s), .uart_m(uart_m), .idle_m(idle_m),
    .deb_valid(deb_valid), .deb_cycles(deb_cycles), .sck_en(sck_en)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;
  initial forever #(SUB_HALF) sub_clk = ~sub_clk;
  initial forever begin @(posedge sub_clk); sub_rises++; end
  initial forever begin @(negedge clk); if (sck_en) pulses++; end

  function automatic logic [4:0] exp_stb(input logic [7:0] c);
    if (c[4]) return 5'b01000;
    case (c[7:5])
      3'd5: return 5'b00010;
      3'd6: return 5'b00100;
      3'd7: return 5'b10000;
      default: return 5'b00001;
    endcase
  endfunction

  function automatic logic [3:0] exp_deb(input logic [7:0] c);
    logic v;
    v = !c[4] && c[7:5] == 3'd6;
    if (!v) return 4'b0000;
    return {1'b1, c[3] ? 3'd4 : (c[2] ? 3'd2 : 3'd0)};
  endfunction

  function automatic int exp_div(input logic [7:0] c);
    if (!c[1] || c[4]) return 0;
    case (c[7:5])
      3'd0: return 4;
      3'd1: return 16;
      3'd2: return 64;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Called right after write(): observe W edges, checking first pulse and spacing.
  task automatic div_window(input string req, input int n, input int w);
    int first = 0;
    int last = 0;
    int cnt = 0;
    int gap_bad = 0;
    for (int i = 1; i <= w; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (sck_en) begin
        if (cnt == 0) first = i;
        else if (i - last != n) gap_bad++;
        last = i;
        cnt++;
      end
    end
    chk({req, " R9 first pulse edge"}, first, n + 1);
    chk({req, " R5 pulse count"}, cnt, (w - 1) / n);
    chk({req, " R5 pulse spacing errors"}, gap_bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: run hung (actual=running expected=finished)");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p0, s0, m, d;
    logic [7:0] c;
    void'($urandom(32'd20240611));
    cycles(3);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 cfg_rd", cfg_rd, 8'hE0);
    chk("R1 strobes", {idle_m, uart_m, i2c_s, spi_s, spi_m}, 5'b10000);
    chk("R1 sck_en", sck_en, 0);
    chk("R1 deb_valid", deb_valid, 0);

    // R5 / R9 each divider from a disabled state
    write(8'h02); div_window("div4", 4, 200);
    write(8'hE0); cycles(3);
    write(8'h22); div_window("div16", 16, 200);
    write(8'hE0); cycles(3);
    write(8'h42); div_window("div64", 64, 200);

    // R9 mid-period change from /64 to /4
    cycles(37);
    write(8'h02); div_window("switch64to4", 4, 60);

    // R8 enable low, R4 UART override
    write(8'h00); cycles(2);
    p0 = pulses; cycles(120);
    chk("R8 disabled pulses", pulses - p0, 0);
    write(8'h12); cycles(2);
    chk("R4 strobes uart over code 000", {idle_m, uart_m, i2c_s, spi_s, spi_m}, 5'b01000);
    p0 = pulses; cycles(120);
    chk("R4 uart pulses", pulses - p0, 0);
    write(8'hD2); cycles(2);
    chk("R4 strobes uart over code 110", {idle_m, uart_m, i2c_s, spi_s, spi_m}, 5'b01000);
    chk("R10 deb_valid in uart", deb_valid, 0);

    // R6 sub-clock source
    write(8'hE0); cycles(3);
    write(8'h62); cycles(10);
    p0 = pulses; s0 = sub_rises;
    cycles(400);
    d = (pulses - p0) - (sub_rises - s0);
    chk("R6 pulse vs sub edge mismatch>1", (d > 1 || d < -1) ? 1 : 0, 0);
    chk("R6 some pulses", (pulses - p0) > 15 ? 1 : 0, 1);

    // R7 timer source, including back-to-back matches
    write(8'hE0); cycles(3);
    write(8'h82); cycles(3);
    p0 = pulses; m = 0;
    for (int i = 0; i < 61; i++) begin
      tmr_match = (i < 6) ? 1'b1 : 1'($urandom % 2);
      if (tmr_match) m++;
      @(negedge clk);
    end
    tmr_match = 1'b0;
    cycles(4);
    chk("R7 pulses per two matches", pulses - p0, m / 2);

    // R7/R8 matches in a non-timer mode are ignored
    write(8'hA2); cycles(2);
    p0 = pulses;
    for (int i = 0; i < 20; i++) begin
      tmr_match = 1'b1;
      @(negedge clk);
    end
    tmr_match = 1'b0;
    cycles(3);
    chk("R8 slave mode ignores matches", pulses - p0, 0);

    // Random configurations: R2, R3, R10, R5, R8
    for (int it = 0; it < 48; it++) begin
      c = 8'($urandom);
      if (it < 4) c = {6'b110_0_00, 2'(it)} | 8'(it << 2);
      write(8'hE0);
      write(c);
      chk("R2 cfg_rd", cfg_rd, c);
      @(negedge clk);
      chk("R3 strobes", {idle_m, uart_m, i2c_s, spi_s, spi_m}, exp_stb(c));
      chk("R10 deb", {deb_valid, deb_cycles}, exp_deb(c));
      if (!(c[7:5] == 3'd3 && c[1] && !c[4])) begin
        p0 = pulses;
        cycles(138);
        chk("R5 R8 random window pulses", pulses - p0,
            exp_div(c) == 0 ? 0 : (140 - 1) / exp_div(c) - (exp_div(c) == 4 ? 0 : 0)
              - ((exp_div(c) != 0 && 140 - 1 - ((140 - 1) / exp_div(c)) * exp_div(c) < 1) ? 1 : 0));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule